// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits between a host write port and the write controller of a byte-wide non-volatile memory array. It watches every byte-write event, each carrying an address and a data byte. It recognises two keyed command strings. A three-byte lock key arms write protection for a block. A six-byte release key removes it. The detector holds one protect bit per memory block and tells the write controller, in the same cycle as each write, whether that byte may change the array.

A write to a protected block without the key still goes to the write controller, which runs its full program period, but the detector holds the commit flag low so that no data changes. After a lock key, data bytes to the keyed block are committed until the end of the current write period. At that point the pending lock or release takes effect. The write controller marks the end of each write period with a one-cycle `cycle_done` pulse.

The protect bits are held in an ordinary resettable register. Their reset value is set by a parameter, and it defaults to all blocks open.

Top module: `swp_cmd_detector`

## Requirements
- R1: After a synchronous active-low reset, `protect_vec` equals `INIT_PROTECT`, which defaults to all zeros. With the default value, every write is committed.
- R2: A write to a block whose protect bit is 0 has `commit_allowed` = 1 in that write's cycle. This includes bytes that form part of a key.
- R3: The lock key is data 8'hAA at low address 15'h5555, then 8'h55 at 15'h2AAA, then 8'hA0 at 15'h5555. Only the low 15 address bits are compared. The block is the upper address bits of the final key byte. That block's protect bit is set on the `cycle_done` pulse that follows, and not before, even if no data byte follows the key.
- R4: A write to a protected block that is not granted by a key has `commit_allowed` = 0, and `protect_vec` does not change.
- R5: After a lock key to a protected block, data bytes to that block commit until the next `cycle_done`. The key bytes themselves do not commit. Writes to other protected blocks are still refused. After the `cycle_done`, the grant is gone.
- R6: The release key is 8'hAA@5555, 8'h55@2AAA, 8'h80@5555, 8'hAA@5555, 8'h55@2AAA, 8'h20@5555. The protect bit of the final byte's block clears on the next `cycle_done`. Until then, data to that block commits.
- R7: A byte that does not continue a partial key returns the matcher to idle. If that byte is itself 8'hAA@5555, it counts as the first byte of a new key.
- R8: Each block has its own protect bit. Any combination of bits may be set, and locking or releasing one block leaves the others unchanged.
- R9: If a key completes in the same cycle as `cycle_done`, its effect is deferred to the following `cycle_done`.
- R10: `protect_vec` changes only in the cycle after a `cycle_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A byte-write event is present this cycle |
| wr_addr | input | ADDR_W | Write address; the upper ADDR_W-15 bits select the block |
| wr_data | input | 8 | Write data byte |
| cycle_done | input | 1 | One-cycle pulse at the end of a write period |
| commit_allowed | output | 1 | The present write may change the array |
| protect_vec | output | 2**(ADDR_W-15) | Protect bit of each block |

## Verification
The hardest case to reach from the ports is a key that completes in the same clock as `cycle_done`. There, an off-by-one in the pending logic would either apply the lock at once or lose it. The bench drives the final lock byte together with the end-of-period pulse. It then checks that the bit stays clear across that edge and sets on the next pulse. The re-examination rule is reached by a repeated 8'hAA@5555 that arrives while the matcher is waiting for the second key byte, followed by the rest of the key and a data byte that must commit.

// File: rtl/swp_pkg.sv
// Shared constants and types for the software write-protect detector.
// Assumes the key addresses fit in the low KEY_W address bits.
package swp_pkg;
    localparam int KEY_W = 15;
    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0] KEY_D0    = 8'hAA;
    localparam logic [7:0] KEY_D1    = 8'h55;
    localparam logic [7:0] CMD_LOCK  = 8'hA0;
    localparam logic [7:0] CMD_EXT   = 8'h80;
    localparam logic [7:0] CMD_CLEAR = 8'h20;

    // Number of key bytes matched so far.
    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_GOT1 = 3'd1,
        SEQ_GOT2 = 3'd2,
        SEQ_GOT3 = 3'd3,
        SEQ_GOT4 = 3'd4,
        SEQ_GOT5 = 3'd5
    } seq_state_t;
endpackage

// File: rtl/swp_seq_matcher.sv
// Key-string matcher shared by all blocks. It tracks progress through the
// lock key (3 bytes) and the release key (6 bytes), which share their
// first two bytes. It flags key bytes and key completion in the cycle of
// the write. Assumes at most one write event per cycle.
module swp_seq_matcher
    import swp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] key_addr,
    input  logic [7:0]       wr_data,
    output logic             seq_byte,
    output logic             lock_done,
    output logic             clear_done
);
    seq_state_t state, state_nxt;
    logic is_a, is_b, first_hit, hit;

    // Decode the current byte and choose the next matcher state.
    always_comb begin
        is_a       = (key_addr == KEY_ADDR_A);
        is_b       = (key_addr == KEY_ADDR_B);
        first_hit  = is_a && (wr_data == KEY_D0);
        state_nxt  = state;
        hit        = 1'b0;
        lock_done  = 1'b0;
        clear_done = 1'b0;
        if (wr_valid) begin
            case (state)
                SEQ_IDLE: hit = first_hit;
                SEQ_GOT1: hit = is_b && (wr_data == KEY_D1);
                SEQ_GOT2: hit = is_a && ((wr_data == CMD_LOCK) || (wr_data == CMD_EXT));
                SEQ_GOT3: hit = first_hit;
                SEQ_GOT4: hit = is_b && (wr_data == KEY_D1);
                SEQ_GOT5: hit = is_a && (wr_data == CMD_CLEAR);
                default:  hit = 1'b0;
            endcase
            if (hit) begin
                case (state)
                    SEQ_IDLE: state_nxt = SEQ_GOT1;
                    SEQ_GOT1: state_nxt = SEQ_GOT2;
                    SEQ_GOT2: begin
                        if (wr_data == CMD_LOCK) begin
                            state_nxt = SEQ_IDLE;
                            lock_done = 1'b1;
                        end else begin
                            state_nxt = SEQ_GOT3;
                        end
                    end
                    SEQ_GOT3: state_nxt = SEQ_GOT4;
                    SEQ_GOT4: state_nxt = SEQ_GOT5;
                    SEQ_GOT5: begin
                        state_nxt  = SEQ_IDLE;
                        clear_done = 1'b1;
                    end
                    default:  state_nxt = SEQ_IDLE;
                endcase
            end else begin
                // A breaking byte may itself open a new key (R7).
                state_nxt = first_hit ? SEQ_GOT1 : SEQ_IDLE;
            end
        end
        seq_byte = wr_valid && (hit || first_hit);
    end

    // Hold matcher progress between write events.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nxt;
    end

    // R3/R6: one write cannot complete both keys.
    p_one_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_done && clear_done));
    // R7: every key completion returns the matcher to idle.
    p_idle_after_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_done || clear_done) |=> (state == SEQ_IDLE));
    // R7: completion is only ever reported on a key byte.
    p_done_on_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_done || clear_done) |-> seq_byte);
endmodule

// File: rtl/swp_protect_bank.sv
// Per-block protect register with pending lock and release vectors. A key
// completion marks its block as pending. The pending state is applied on the
// next end-of-period pulse. Pending blocks are granted data writes until then.
// Assumes cycle_done is a single-cycle pulse from the write controller.
module swp_protect_bank #(
    parameter int NUM_BLK = 4,
    parameter int BLK_W   = 2,
    parameter logic [NUM_BLK-1:0] INIT_PROTECT = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_done,
    input  logic               clear_done,
    input  logic [BLK_W-1:0]   blk_sel,
    input  logic               cycle_done,
    output logic [NUM_BLK-1:0] protect_vec,
    output logic [NUM_BLK-1:0] grant_vec
);
    logic [NUM_BLK-1:0] pend_set, pend_clr;
    logic [NUM_BLK-1:0] set_nxt, clr_nxt, prot_nxt;
    logic [NUM_BLK-1:0] blk_onehot;

    // One-hot decode of the addressed block.
    for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_dec
        assign blk_onehot[gi] = (blk_sel == BLK_W'(gi));
    end

    // Retire pending work at period end, then add any new key completion.
    always_comb begin
        set_nxt  = cycle_done ? '0 : pend_set;
        clr_nxt  = cycle_done ? '0 : pend_clr;
        prot_nxt = cycle_done ? ((protect_vec | pend_set) & ~pend_clr) : protect_vec;
        if (lock_done) begin
            set_nxt = set_nxt | blk_onehot;
            clr_nxt = clr_nxt & ~blk_onehot;
        end
        if (clear_done) begin
            clr_nxt = clr_nxt | blk_onehot;
            set_nxt = set_nxt & ~blk_onehot;
        end
    end

    // Protect and pending registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            protect_vec <= INIT_PROTECT;
            pend_set    <= '0;
            pend_clr    <= '0;
        end else begin
            protect_vec <= prot_nxt;
            pend_set    <= set_nxt;
            pend_clr    <= clr_nxt;
        end
    end

    // Blocks with a key in flight accept data for the rest of the period.
    assign grant_vec = pend_set | pend_clr;

    // R10: protect bits move only right after a period end.
    p_hold_between_periods_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_done |=> $stable(protect_vec));
    // R6: a block is never pending both lock and release.
    p_pend_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set & pend_clr) == '0);
    // R9: a period end with no new key leaves nothing granted.
    p_grant_retired_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && !lock_done && !clear_done) |=> (grant_vec == '0));
endmodule

// File: rtl/swp_commit_gate.sv
// Decides whether the present write may change the array. Open blocks always
// commit. Protected blocks commit only data bytes while granted.
// Assumes protect_vec and grant_vec come from the protect bank.
module swp_commit_gate #(
    parameter int NUM_BLK = 4,
    parameter int BLK_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [BLK_W-1:0]   blk_sel,
    input  logic               seq_byte,
    input  logic [NUM_BLK-1:0] protect_vec,
    input  logic [NUM_BLK-1:0] grant_vec,
    output logic               commit_allowed
);
    logic blk_prot, blk_grant;

    // Select the addressed block's state and form the commit flag.
    always_comb begin
        blk_prot       = protect_vec[blk_sel];
        blk_grant      = grant_vec[blk_sel];
        commit_allowed = wr_valid && (!blk_prot || (blk_grant && !seq_byte));
    end

    // R2: open blocks are never refused.
    p_open_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !protect_vec[blk_sel]) |-> commit_allowed);
    // R4: protected, ungranted blocks are always refused.
    p_denied_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && protect_vec[blk_sel] && !grant_vec[blk_sel]) |-> !commit_allowed);
    // R5: key bytes to a protected block never commit.
    p_key_not_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_byte && protect_vec[blk_sel]) |-> !commit_allowed);
endmodule

// File: rtl/swp_cmd_detector.sv
// Top of the software write-protect detector. It splits the address into
// the key part and the block part and joins the matcher, the protect bank
// and the commit gate. Assumes ADDR_W > KEY_W.
module swp_cmd_detector
    import swp_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter logic [(1 << (ADDR_W - 15)) - 1:0] INIT_PROTECT = '0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_valid,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [7:0]                         wr_data,
    input  logic                               cycle_done,
    output logic                               commit_allowed,
    output logic [(1 << (ADDR_W - 15)) - 1:0]  protect_vec
);
    localparam int BLK_W   = ADDR_W - KEY_W;
    localparam int NUM_BLK = 1 << BLK_W;

    logic [KEY_W-1:0]   key_addr;
    logic [BLK_W-1:0]   blk_sel;
    logic               seq_byte, lock_done, clear_done;
    logic [NUM_BLK-1:0] grant_vec;

    assign key_addr = wr_addr[KEY_W-1:0];
    assign blk_sel  = wr_addr[ADDR_W-1 -: BLK_W];

    swp_seq_matcher u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .key_addr   (key_addr),
        .wr_data    (wr_data),
        .seq_byte   (seq_byte),
        .lock_done  (lock_done),
        .clear_done (clear_done)
    );

    swp_protect_bank #(
        .NUM_BLK      (NUM_BLK),
        .BLK_W        (BLK_W),
        .INIT_PROTECT (INIT_PROTECT)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_done   (lock_done),
        .clear_done  (clear_done),
        .blk_sel     (blk_sel),
        .cycle_done  (cycle_done),
        .protect_vec (protect_vec),
        .grant_vec   (grant_vec)
    );

    swp_commit_gate #(
        .NUM_BLK (NUM_BLK),
        .BLK_W   (BLK_W)
    ) u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_valid       (wr_valid),
        .blk_sel        (blk_sel),
        .seq_byte       (seq_byte),
        .protect_vec    (protect_vec),
        .grant_vec      (grant_vec),
        .commit_allowed (commit_allowed)
    );

    // R1/R5: no commit without a write event.
    p_commit_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit_allowed |-> wr_valid);
endmodule

// File: tb/swp_cmd_detector_tb_top.sv
`timescale 1ns/1ps
module swp_cmd_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cycle_done = 1'b0;
    logic        commit_allowed;
    logic [3:0]  protect_vec;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    swp_cmd_detector dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_valid       (wr_valid),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .cycle_done     (cycle_done),
        .commit_allowed (commit_allowed),
        .protect_vec    (protect_vec)
    );

    // Entry: [34:31] req, [30] op (1 = period end), [29:28] block,
    // [27:13] low address, [12:5] data, [4] expected commit, [3:0] expected protect.
    localparam int NV = 39;
    localparam logic [34:0] TBL [NV] = '{
        {4'd2, 1'b0, 2'd0, 15'h5555, 8'hAA, 1'b1, 4'h0},
        {4'd2, 1'b0, 2'd0, 15'h2AAA, 8'h55, 1'b1, 4'h0},
        {4'd3, 1'b0, 2'd0, 15'h5555, 8'hA0, 1'b1, 4'h0},
        {4'd3, 1'b0, 2'd0, 15'h0010, 8'h11, 1'b1, 4'h0},
        {4'd3, 1'b1, 2'd0, 15'h0000, 8'h00, 1'b0, 4'h1},
        {4'd4, 1'b0, 2'd0, 15'h0020, 8'h22, 1'b0, 4'h1},
        {4'd8, 1'b0, 2'd1, 15'h0020, 8'h22, 1'b1, 4'h1},
        {4'd10,1'b1, 2'd0, 15'h0000, 8'h00, 1'b0, 4'h1},
        {4'd3, 1'b0, 2'd2, 15'h5555, 8'hAA, 1'b1, 4'h1},
        {4'd3, 1'b0, 2'd2, 15'h2AAA, 8'h55, 1'b1, 4'h1},
        {4'd3, 1'b0, 2'd2, 15'h5555, 8'hA0, 1'b1, 4'h1},
        {4'd8, 1'b1, 2'd0, 15'h0000, 8'h00, 1'b0, 4'h5},
        {4'd5, 1'b0, 2'd0, 15'h5555, 8'hAA, 1'b0, 4'h5},
        {4'd5, 1'b0, 2'd0, 15'h2AAA, 8'h55, 1'b0, 4'h5},
        {4'd5, 1'b0, 2'd0, 15'h5555, 8'hA0, 1'b0, 4'h5},
        {4'd5, 1'b0, 2'd0, 15'h0030, 8'h33, 1'b1, 4'h5},
        {4'd5, 1'b0, 2'd2, 15'h0030, 8'h33, 1'b0, 4'h5},
        {4'd5, 1'b0, 2'd0, 15'h0031, 8'h34, 1'b1, 4'h5},
        {4'd8, 1'b1, 2'd0, 15'h0000, 8'h00, 1'b0, 4'h5},
        {4'd5, 1'b0, 2'd0, 15'h0040, 8'h44, 1'b0, 4'h5},
        {4'd7, 1'b0, 2'd0, 15'h5555, 8'hAA, 1'b0, 4'h5},
        {4'd7, 1'b0, 2'd0, 15'h2AAA, 8'h56, 1'b0, 4'h5},
        {4'd7, 1'b0, 2'd0, 15'h5555, 8'hA0, 1'b0, 4'h5},
        {4'd7, 1'b0, 2'd0, 15'h0041, 8'h45, 1'b0, 4'h5},
        {4'd7, 1'b0, 2'd0, 15'h5555, 8'hAA, 1'b0, 4'h5},
        {4'd7, 1'b0, 2'd0, 15'h5555, 8'hAA, 1'b0, 4'h5},
        {4'd7, 1'b0, 2'd0, 15'h2AAA, 8'h55, 1'b0, 4'h5},
        {4'd7, 1'b0, 2'd0, 15'h5555, 8'hA0, 1'b0, 4'h5},
        {4'd7, 1'b0, 2'd0, 15'h0042, 8'h46, 1'b1, 4'h5},
        {4'd7, 1'b1, 2'd0, 15'h0000, 8'h00, 1'b0, 4'h5},
        {4'd6, 1'b0, 2'd2, 15'h5555, 8'hAA, 1'b0, 4'h5},
        {4'd6, 1'b0, 2'd2, 15'h2AAA, 8'h55, 1'b0, 4'h5},
        {4'd6, 1'b0, 2'd2, 15'h5555, 8'h80, 1'b0, 4'h5},
        {4'd6, 1'b0, 2'd2, 15'h5555, 8'hAA, 1'b0, 4'h5},
        {4'd6, 1'b0, 2'd2, 15'h2AAA, 8'h55, 1'b0, 4'h5},
        {4'd6, 1'b0, 2'd2, 15'h5555, 8'h20, 1'b0, 4'h5},
        {4'd6, 1'b0, 2'd2, 15'h0050, 8'h55, 1'b1, 4'h5},
        {4'd6, 1'b1, 2'd0, 15'h0000, 8'h00, 1'b0, 4'h1},
        {4'd6, 1'b0, 2'd2, 15'h0051, 8'h56, 1'b1, 4'h1}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One vector: drive after a falling edge, check commit, clock, check protect.
    task automatic run_step(input bit op, input logic [1:0] blk, input logic [14:0] low,
                            input logic [7:0] data, input bit exp_c, input logic [3:0] exp_p,
                            input string tag);
        wr_valid   = !op;
        cycle_done = op;
        wr_addr    = {blk, low};
        wr_data    = data;
        #1;
        if (!op) check(commit_allowed == exp_c, tag, "commit", 32'(commit_allowed), 32'(exp_c));
        @(posedge clk);
        @(negedge clk);
        wr_valid   = 1'b0;
        cycle_done = 1'b0;
        check(protect_vec == exp_p, tag, "protect", 32'(protect_vec), 32'(exp_p));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, all blocks open.
        check(protect_vec == 4'h0, "R1", "reset protect", 32'(protect_vec), 32'h0);
        run_step(1'b0, 2'd3, 15'h0001, 8'h01, 1'b1, 4'h0, "R1");

        for (int i = 0; i < NV; i++) begin
            run_step(TBL[i][30], TBL[i][29:28], TBL[i][27:13], TBL[i][12:5],
                     TBL[i][4], TBL[i][3:0], req_name(TBL[i][34:31]));
        end

        // R9: lock key on block 3 finishing in the same cycle as period end.
        run_step(1'b0, 2'd3, 15'h5555, 8'hAA, 1'b1, 4'h1, "R9");
        run_step(1'b0, 2'd3, 15'h2AAA, 8'h55, 1'b1, 4'h1, "R9");
        wr_valid   = 1'b1;
        cycle_done = 1'b1;
        wr_addr    = {2'd3, 15'h5555};
        wr_data    = 8'hA0;
        @(posedge clk);
        @(negedge clk);
        wr_valid   = 1'b0;
        cycle_done = 1'b0;
        check(protect_vec == 4'h1, "R9", "deferred protect", 32'(protect_vec), 32'h1);
        run_step(1'b1, 2'd0, 15'h0, 8'h00, 1'b0, 4'h9, "R9");
        run_step(1'b0, 2'd3, 15'h0060, 8'h66, 1'b0, 4'h9, "R4");

        // R1: a reset mid-run returns every block to open.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(protect_vec == 4'h0, "R1", "protect after reset", 32'(protect_vec), 32'h0);
        run_step(1'b0, 2'd0, 15'h0070, 8'h77, 1'b1, 4'h0, "R1");

        finish_run();
    end
endmodule